// File: doc/BRIEF.md
# Vector-Prefix Instruction Fault Classifier

This block takes one decoded instruction that uses the vector-extension prefix and decides which single fault it must raise, or that it raises none. It looks at the operating mode, the prefix flags the decoder found, the feature-present flag, the relevant control and enable bits, the address-check results from the memory stage, and the SIMD floating-point status and mask. If several faults apply, only the most urgent one is reported.

A check starts when `chk_valid` is high at a rising clock edge. The verdict is registered: one cycle later `fault_valid` pulses for one cycle. With it come `fault_raise` and the fault vector number on `fault_vec`. The block does not check operand alignment and does not translate addresses. It only uses the flags that the memory stage has already computed.

Top module: `vxf_classifier`

## Requirements
- R1: `fault_valid` is high in exactly the cycle after each cycle in which `chk_valid` is high, and low otherwise. Whenever `fault_valid` is low, `fault_raise` is 0 and `fault_vec` is 0.
- R2: Vector codes on `fault_vec` are: illegal-opcode 6, device-not-available 7, stack fault 12, general protection 13, page fault 14, SIMD floating-point 19. When no fault applies, `fault_raise`=0 and `fault_vec`=0.
- R3: In the two legacy modes (`mode` 0 = real, 1 = virtual-8086), every checked instruction yields illegal-opcode.
- R4: In protected (`mode`=2) or 64-bit (`mode`=3) mode, illegal-opcode is raised when either of the two bits of `xstate_en` is 0, or when `os_save_en` is 0.
- R5: In every mode, illegal-opcode is raised when `has_lock` is 1 or when `feat_present` is 0.
- R6: In protected or 64-bit mode, illegal-opcode is raised when `has_legacy_pfx` is 1. This flag means a REX, F2, F3 or 66 prefix came before the vector prefix.
- R7: Device-not-available is raised when `task_switched` is 1 and no illegal-opcode cause exists.
- R8: An address fault is raised in protected mode when `mem_seg_fault` is 1, and in 64-bit mode when `mem_noncanon` is 1. It is a stack fault when `mem_stack_ref` is 1 and general protection otherwise. `mem_noncanon` has no effect in protected mode, and `mem_seg_fault` has no effect in 64-bit mode.
- R9: `mem_page_fault` raises a page fault when no higher-priority fault applies.
- R10: An unmasked SIMD exception is any bit set in `simd_status` whose bit in `simd_mask` is 0. It raises the SIMD fault when `simd_report_en` is 1, and illegal-opcode when `simd_report_en` is 0. Exceptions that are all masked raise nothing.
- R11: Priority, from highest to lowest: illegal-opcode, device-not-available, stack/general, page, SIMD slot. Only the winning fault is reported.
- R12: The alignment-check vector (17) is never produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chk_valid | input | 1 | Instruction presented for checking this cycle |
| mode | input | 2 | 0 real, 1 virtual-8086, 2 protected/compatibility, 3 64-bit |
| has_lock | input | 1 | LOCK prefix present |
| has_legacy_pfx | input | 1 | REX/F2/F3/66 prefix precedes the vector prefix |
| feat_present | input | 1 | Feature flag for this instruction is set |
| os_save_en | input | 1 | OS extended-state save enable control bit |
| xstate_en | input | 2 | Extended-state enable mask bits 2:1 |
| task_switched | input | 1 | Task-switched control bit |
| simd_report_en | input | 1 | OS SIMD exception reporting enable control bit |
| mem_seg_fault | input | 1 | Effective address violates segment limits |
| mem_noncanon | input | 1 | Address is non-canonical |
| mem_stack_ref | input | 1 | Access is through the stack segment |
| mem_page_fault | input | 1 | Memory stage reported a page fault |
| simd_status | input | SIMD_FLAGS | SIMD floating-point exception status flags |
| simd_mask | input | SIMD_FLAGS | SIMD floating-point exception masks (1 = masked) |
| fault_valid | output | 1 | One-cycle verdict strobe |
| fault_raise | output | 1 | A fault applies |
| fault_vec | output | 8 | Vector number of the reported fault |

## Verification
Every verdict is due exactly one clock after the edge that sampled `chk_valid`, because it passes through a single output register. The bench drives each instruction on a falling edge and reads `fault_valid`, `fault_raise` and `fault_vec` on the next falling edge, which lies after the capturing rising edge. Idle cycles are read the same way, one cycle after `chk_valid` was low, to confirm that the strobe stays low and the code is cleared. Random instructions are mixed with directed cases that place several faults in the same instruction, so that the priority order is exercised.

// File: rtl/vxf_pkg.sv
package vxf_pkg;

    localparam int SIMD_FLAGS_DEF = 6;
    localparam int VEC_W          = 8;

    typedef enum logic [1:0] {
        MODE_REAL = 2'd0,
        MODE_V86  = 2'd1,
        MODE_PROT = 2'd2,
        MODE_LONG = 2'd3
    } op_mode_e;

    typedef enum logic [VEC_W-1:0] {
        VEC_NONE    = 8'd0,
        VEC_ILLEGAL = 8'd6,
        VEC_NODEV   = 8'd7,
        VEC_STACK   = 8'd12,
        VEC_GENERAL = 8'd13,
        VEC_PAGE    = 8'd14,
        VEC_ALIGN   = 8'd17,
        VEC_SIMD    = 8'd19
    } fault_vec_e;

    typedef struct packed {
        logic       hit;
        fault_vec_e vec;
    } verdict_t;

    localparam verdict_t NO_VERDICT = '{hit: 1'b0, vec: VEC_NONE};

    // Priority slots, index 0 is most urgent
    localparam int SLOT_ILLEGAL = 0;
    localparam int SLOT_NODEV   = 1;
    localparam int SLOT_ADDR    = 2;
    localparam int SLOT_PAGE    = 3;
    localparam int SLOT_SIMD    = 4;
    localparam int N_SLOTS      = 5;

    function automatic logic is_legacy_mode(op_mode_e m);
        return (m == MODE_REAL) || (m == MODE_V86);
    endfunction

    function automatic verdict_t make_verdict(logic hit, fault_vec_e vec);
        verdict_t v;
        v.hit = hit;
        v.vec = hit ? vec : VEC_NONE;
        return v;
    endfunction

endpackage

// File: rtl/vxf_prefix_chk.sv
module vxf_prefix_chk
    import vxf_pkg::*;
(
    input  op_mode_e   mode,
    input  logic       has_lock,
    input  logic       has_legacy_pfx,
    input  logic       feat_present,
    input  logic       os_save_en,
    input  logic [1:0] xstate_en,
    input  logic       task_switched,
    output verdict_t   ill_v,
    output verdict_t   nodev_v
);
    logic legacy;
    logic any_mode_bad;
    logic paged_mode_bad;

    always_comb begin
        legacy         = is_legacy_mode(mode);
        any_mode_bad   = has_lock || !feat_present;
        paged_mode_bad = !legacy &&
                         ((xstate_en != 2'b11) || !os_save_en || has_legacy_pfx);
        ill_v          = make_verdict(legacy || any_mode_bad || paged_mode_bad,
                                      VEC_ILLEGAL);
        nodev_v        = make_verdict(task_switched, VEC_NODEV);
    end
endmodule

// File: rtl/vxf_mem_chk.sv
module vxf_mem_chk
    import vxf_pkg::*;
(
    input  op_mode_e mode,
    input  logic     mem_seg_fault,
    input  logic     mem_noncanon,
    input  logic     mem_stack_ref,
    input  logic     mem_page_fault,
    output verdict_t addr_v,
    output verdict_t page_v
);
    logic bad_addr;

    always_comb begin
        unique case (mode)
            MODE_PROT: bad_addr = mem_seg_fault;
            MODE_LONG: bad_addr = mem_noncanon;
            default:   bad_addr = 1'b0;
        endcase
        addr_v = make_verdict(bad_addr,
                              mem_stack_ref ? VEC_STACK : VEC_GENERAL);
        page_v = make_verdict(mem_page_fault && !is_legacy_mode(mode), VEC_PAGE);
    end
endmodule

// File: rtl/vxf_simd_chk.sv
module vxf_simd_chk
    import vxf_pkg::*;
#(
    parameter int N_FLAGS = SIMD_FLAGS_DEF
) (
    input  logic [N_FLAGS-1:0] status,
    input  logic [N_FLAGS-1:0] mask,
    input  logic               report_en,
    output verdict_t           simd_v
);
    logic [N_FLAGS-1:0] live;

    for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
        assign live[g] = status[g] & ~mask[g];
    end

    always_comb begin
        simd_v = make_verdict(|live, report_en ? VEC_SIMD : VEC_ILLEGAL);
    end
endmodule

// File: rtl/vxf_fault_arb.sv
module vxf_fault_arb
    import vxf_pkg::*;
#(
    parameter int N_SRC = N_SLOTS
) (
    input  verdict_t src [N_SRC],
    output verdict_t win
);
    always_comb begin
        win = NO_VERDICT;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (src[i].hit) win = src[i];
        end
    end
endmodule

// File: rtl/vxf_classifier.sv
module vxf_classifier
    import vxf_pkg::*;
#(
    parameter int SIMD_FLAGS = SIMD_FLAGS_DEF
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  chk_valid,
    input  logic [1:0]            mode,
    input  logic                  has_lock,
    input  logic                  has_legacy_pfx,
    input  logic                  feat_present,
    input  logic                  os_save_en,
    input  logic [1:0]            xstate_en,
    input  logic                  task_switched,
    input  logic                  simd_report_en,
    input  logic                  mem_seg_fault,
    input  logic                  mem_noncanon,
    input  logic                  mem_stack_ref,
    input  logic                  mem_page_fault,
    input  logic [SIMD_FLAGS-1:0] simd_status,
    input  logic [SIMD_FLAGS-1:0] simd_mask,
    output logic                  fault_valid,
    output logic                  fault_raise,
    output logic [VEC_W-1:0]      fault_vec
);
    op_mode_e op_mode;
    verdict_t slots [N_SLOTS];
    verdict_t winner;
    verdict_t result_q;

    assign op_mode = op_mode_e'(mode);

    vxf_prefix_chk u_prefix (
        .mode           (op_mode),
        .has_lock       (has_lock),
        .has_legacy_pfx (has_legacy_pfx),
        .feat_present   (feat_present),
        .os_save_en     (os_save_en),
        .xstate_en      (xstate_en),
        .task_switched  (task_switched),
        .ill_v          (slots[SLOT_ILLEGAL]),
        .nodev_v        (slots[SLOT_NODEV])
    );

    vxf_mem_chk u_mem (
        .mode           (op_mode),
        .mem_seg_fault  (mem_seg_fault),
        .mem_noncanon   (mem_noncanon),
        .mem_stack_ref  (mem_stack_ref),
        .mem_page_fault (mem_page_fault),
        .addr_v         (slots[SLOT_ADDR]),
        .page_v         (slots[SLOT_PAGE])
    );

    vxf_simd_chk #(.N_FLAGS(SIMD_FLAGS)) u_simd (
        .status    (simd_status),
        .mask      (simd_mask),
        .report_en (simd_report_en),
        .simd_v    (slots[SLOT_SIMD])
    );

    vxf_fault_arb #(.N_SRC(N_SLOTS)) u_arb (
        .src (slots),
        .win (winner)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fault_valid <= 1'b0;
            result_q    <= NO_VERDICT;
        end else begin
            fault_valid <= chk_valid;
            result_q    <= chk_valid ? winner : NO_VERDICT;
        end
    end

    assign fault_raise = result_q.hit;
    assign fault_vec   = result_q.vec;

    // R1
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        chk_valid |=> fault_valid);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !chk_valid |=> (!fault_valid && !fault_raise && fault_vec == '0));
    // R3
    legacy_mode_ill_chk: assert property (@(posedge clk) disable iff (rst)
        (chk_valid && mode[1] == 1'b0) |=> (fault_raise && fault_vec == VEC_ILLEGAL));
    // R5
    lock_ill_chk: assert property (@(posedge clk) disable iff (rst)
        (chk_valid && (has_lock || !feat_present)) |=> (fault_vec == VEC_ILLEGAL));
    // R10
    simd_gated_chk: assert property (@(posedge clk) disable iff (rst)
        (chk_valid && !simd_report_en) |=> (fault_vec != VEC_SIMD));
    // R2
    code_set_chk: assert property (@(posedge clk) disable iff (rst)
        fault_raise |-> (fault_vec == VEC_ILLEGAL || fault_vec == VEC_NODEV ||
                         fault_vec == VEC_STACK   || fault_vec == VEC_GENERAL ||
                         fault_vec == VEC_PAGE    || fault_vec == VEC_SIMD));
    // R12
    no_align_chk: assert property (@(posedge clk) disable iff (rst)
        fault_vec != VEC_ALIGN);
endmodule

// File: tb/vxf_classifier_tb.sv
`timescale 1ns/1ps
module vxf_classifier_tb;
    localparam int NF = 6;

    typedef struct packed {
        logic [1:0]    mode;
        logic          lock;
        logic          pfx;
        logic          feat;
        logic          os;
        logic [1:0]    xs;
        logic          ts;
        logic          en;
        logic          seg;
        logic          nc;
        logic          stk;
        logic          pf;
        logic [NF-1:0] st;
        logic [NF-1:0] mk;
    } stim_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic chk_valid = 1'b0;
    stim_t s = '0;
    logic fault_valid, fault_raise;
    logic [7:0] fault_vec;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    vxf_classifier #(.SIMD_FLAGS(NF)) u_dut (
        .clk(clk), .rst(rst), .chk_valid(chk_valid), .mode(s.mode),
        .has_lock(s.lock), .has_legacy_pfx(s.pfx), .feat_present(s.feat),
        .os_save_en(s.os), .xstate_en(s.xs), .task_switched(s.ts),
        .simd_report_en(s.en), .mem_seg_fault(s.seg), .mem_noncanon(s.nc),
        .mem_stack_ref(s.stk), .mem_page_fault(s.pf), .simd_status(s.st),
        .simd_mask(s.mk), .fault_valid(fault_valid), .fault_raise(fault_raise),
        .fault_vec(fault_vec)
    );

    // Expected {raise, vec} from the requirements
    function automatic logic [8:0] expect_of(stim_t x, output string tag);
        logic legacy = (x.mode < 2);
        if (legacy) begin tag = "R3"; return {1'b1, 8'd6}; end
        if (x.lock || !x.feat) begin tag = "R5"; return {1'b1, 8'd6}; end
        if (x.xs != 2'b11 || !x.os) begin tag = "R4"; return {1'b1, 8'd6}; end
        if (x.pfx) begin tag = "R6"; return {1'b1, 8'd6}; end
        if (x.ts) begin tag = "R7"; return {1'b1, 8'd7}; end
        if ((x.mode == 2 && x.seg) || (x.mode == 3 && x.nc)) begin
            tag = "R8"; return {1'b1, x.stk ? 8'd12 : 8'd13};
        end
        if (x.pf) begin tag = "R9"; return {1'b1, 8'd14}; end
        if (|(x.st & ~x.mk)) begin tag = "R10"; return {1'b1, x.en ? 8'd19 : 8'd6}; end
        tag = "R11"; return {1'b0, 8'd0};
    endfunction

    task automatic check(string req, logic [9:0] act, logic [9:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s R2 valid/raise/vec act=%b/%b/%0d exp=%b/%b/%0d",
                     req, act[9], act[8], act[7:0], exp[9], exp[8], exp[7:0]);
        end
        if (fault_vec == 8'd17) begin
            errors++;
            $display("FAIL R12 act=%0d exp=not 17", fault_vec);
        end
    endtask

    task automatic run(stim_t x, string note);
        string tag;
        logic [8:0] e;
        @(negedge clk);
        s = x; chk_valid = 1'b1;
        e = expect_of(x, tag);
        @(negedge clk);
        chk_valid = 1'b0;
        check({tag, " ", note}, {fault_valid, fault_raise, fault_vec}, {1'b1, e});
    endtask

    task automatic idle();
        @(negedge clk);
        chk_valid = 1'b0;
        s = stim_t'({$urandom, $urandom});
        @(negedge clk);
        check("R1 idle", {fault_valid, fault_raise, fault_vec}, 10'd0);
    endtask

    function automatic stim_t clean(logic [1:0] m);
        stim_t x = '0;
        x.mode = m; x.feat = 1'b1; x.os = 1'b1; x.xs = 2'b11; x.en = 1'b1;
        x.mk = '1;
        return x;
    endfunction

    function automatic stim_t rnd();
        stim_t x;
        x.mode = 2'($urandom_range(0, 3));
        x.lock = ($urandom_range(0, 7) == 0);
        x.pfx  = ($urandom_range(0, 7) == 0);
        x.feat = ($urandom_range(0, 7) != 0);
        x.os   = ($urandom_range(0, 7) != 0);
        x.xs   = ($urandom_range(0, 7) != 0) ? 2'b11 : 2'($urandom_range(0, 2));
        x.ts   = ($urandom_range(0, 5) == 0);
        x.en   = ($urandom_range(0, 3) != 0);
        x.seg  = ($urandom_range(0, 4) == 0);
        x.nc   = ($urandom_range(0, 4) == 0);
        x.stk  = 1'($urandom_range(0, 1));
        x.pf   = ($urandom_range(0, 4) == 0);
        for (int i = 0; i < NF; i++) begin
            x.st[i] = ($urandom_range(0, 5) == 0);
            x.mk[i] = ($urandom_range(0, 2) != 0);
        end
        return x;
    endfunction

    initial begin
        stim_t x;
        void'($urandom(32'h1d5e_ed07));
        repeat (3) @(negedge clk);
        check("R1 reset", {fault_valid, fault_raise, fault_vec}, 10'd0);
        rst = 1'b0;
        idle();

        run(clean(0), "real clean");
        run(clean(1), "v86 clean");
        run(clean(2), "prot clean none");
        run(clean(3), "long clean none");
        x = clean(3); x.lock = 1; run(x, "lock");
        x = clean(2); x.feat = 0; run(x, "feature off");
        x = clean(3); x.xs = 2'b01; run(x, "xstate bit2 off");
        x = clean(2); x.xs = 2'b10; run(x, "xstate bit1 off");
        x = clean(3); x.os = 0; run(x, "os save off");
        x = clean(2); x.pfx = 1; run(x, "legacy prefix");
        x = clean(3); x.ts = 1; x.seg = 1; x.nc = 1; x.pf = 1; run(x, "nodev over addr");
        x = clean(2); x.seg = 1; x.stk = 1; run(x, "prot stack");
        x = clean(2); x.nc = 1; run(x, "prot noncanon ignored");
        x = clean(3); x.seg = 1; x.pf = 0; run(x, "long seg ignored");
        x = clean(3); x.nc = 1; x.pf = 1; run(x, "long general over page");
        x = clean(2); x.pf = 1; x.st = 6'h1; x.mk = 6'h0; run(x, "page over simd");
        x = clean(3); x.st = 6'h20; x.mk = 6'h1f; run(x, "simd unmasked");
        x = clean(3); x.st = 6'h20; x.mk = 6'h1f; x.en = 0; run(x, "simd report off");
        x = clean(2); x.st = 6'h3f; x.mk = 6'h3f; run(x, "simd all masked");
        x = clean(0); x.ts = 1; x.pf = 1; run(x, "real over nodev");
        idle();

        for (int n = 0; n < 1500; n++) begin
            run(rnd(), "random");
            if ($urandom_range(0, 9) == 0) idle();
        end

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog R1 act=timeout exp=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule